// File: doc/BRIEF.md
# Multirate TDM Highway Slot Port

This block is the system-side serial port of a device that shares a time-division multiplexed highway with other devices. The highway carries 32, 64 or 128 byte-wide time slots per frame, at 2.048, 4.096 or 8.192 Mb/s. Whatever the rate, this device always owns exactly 32 of those slots. A frame-sync pulse sets the position of slot 0. From the local clock, the block counts bit positions and highway slots, and it works out whether the current slot is owned by this device. It also works out the local slot number of an owned slot, from 0 to 31.

In owned slots, the block drives the transmit byte onto the serial output, most significant bit first. The byte comes from the host through a byte interface, selected by the local slot number, which the block shows on `cur_slot`. In the same owned slots, the block shifts in the serial input and delivers each completed byte together with its local slot number. Outside owned slots the output enable is low, so other devices can drive the highway. Two controls can also hold the output enable low: a high-impedance control that overrides everything, and an ordinary output-enable control.

An optional double-clock mode runs the local clock at twice the bit rate. Each bit then lasts two clocks and is sampled on the second one. A fixed-rate control stands for serial-control and standalone operation: it forces the 2.048 Mb/s layout whatever the rate bits say.

Top module: `tdm_slot_port`

## Requirements
- R1: With rate_sel = 3'b000, a frame has 32 highway slots, every slot is owned, and the local index equals the highway slot number.
- R2: With rate_sel[2] = 0 and rate_sel[1] = 1, a frame has 64 slots. A slot is owned when its least significant bit equals rate_sel[0], and its local index is the slot number shifted right by one.
- R3: With rate_sel[2] = 1, a frame has 128 slots. A slot is owned when its two low bits equal rate_sel[1:0], and its local index is the slot number shifted right by two.
- R4: With fixed_rate = 1, the block behaves as in R1 whatever the value of rate_sel.
- R5: With dbl_clk = 1, each bit lasts two clock cycles. The bit position advances, and the input is sampled, only on the second cycle of each pair. With dbl_clk = 0, both happen on every cycle.
- R6: A clock edge with fsync = 1 puts the block at bit 0 of slot 0 (and at the first cycle of the bit in double-clock mode), and that edge captures no input bit.
- R7: During an owned slot, sdout carries tx_data bit (7 - b) at bit position b, so the byte goes out most significant bit first, and cur_slot shows the local index of the current slot.
- R8: The edge that samples bit 7 of an owned slot raises rx_valid for exactly one cycle. rx_byte then holds the eight sampled bits, first-sampled bit as the MSB, and rx_slot holds that slot's local index.
- R9: sdout_oe is high only in an owned slot while out_en = 1 and out_hiz = 0. out_hiz = 1 holds it low throughout the frame.
- R10: While rst_n = 0, the counters are at bit 0 of slot 0 and rx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local highway clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; next cycle starts bit 0 of slot 0 |
| rate_sel | input | 3 | Highway rate and slot offset selection |
| fixed_rate | input | 1 | Forces the 32-slot layout, ignoring rate_sel |
| dbl_clk | input | 1 | Clock runs at twice the bit rate |
| out_hiz | input | 1 | Forces the data output enable low |
| out_en | input | 1 | Ordinary data output enable control |
| sdin | input | 1 | Serial data from the highway |
| tx_data | input | 8 | Transmit byte for the slot shown on cur_slot |
| sdout | output | 1 | Serial data to the highway |
| sdout_oe | output | 1 | Drive enable for sdout |
| cur_slot | output | 5 | Local index of the current highway slot |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received byte |
| rx_slot | output | 5 | Local index of the received byte |

## Verification
The bench runs full frames over a table of configurations. The table covers all three rates, every offset class, double-clock mode, the high-impedance and output-enable controls, and fixed-rate operation with nonzero rate bits. Transmit and receive data vary with the slot number, so any error in ownership or local index shows up as a wrong byte or a wrong enable in a specific slot. Comparing the 64-slot offsets 0 and 1, and the 128-slot offsets 00, 10 and 11, shows whether the block picks the right slots within each rate. A frame sync in the middle of a frame shows whether the counters realign and whether the partly shifted byte is discarded.

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
  parameter int BYTE_W     = 8,
  parameter int BASE_SLOTS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fsync,
  input  logic [2:0]                    rate_sel,
  input  logic                          fixed_rate,
  input  logic                          dbl_clk,
  input  logic                          out_hiz,
  input  logic                          out_en,
  input  logic                          sdin,
  input  logic [BYTE_W-1:0]             tx_data,
  output logic                          sdout,
  output logic                          sdout_oe,
  output logic [$clog2(BASE_SLOTS)-1:0] cur_slot,
  output logic                          rx_valid,
  output logic [BYTE_W-1:0]             rx_byte,
  output logic [$clog2(BASE_SLOTS)-1:0] rx_slot
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int LOC_W = $clog2(BASE_SLOTS);
  localparam int HW_W  = LOC_W + 2;

  logic [2:0]        mode;
  logic              phase;
  logic [BIT_W-1:0]  bitcnt;
  logic [HW_W-1:0]   slot;
  logic [HW_W-1:0]   top_slot;
  logic [LOC_W-1:0]  local_idx;
  logic [BYTE_W-1:0] rx_sh;
  logic              owned, tick, last_bit, cap;

  assign mode     = fixed_rate ? 3'b000 : rate_sel;
  assign tick     = !dbl_clk || phase;
  assign last_bit = bitcnt == BIT_W'(BYTE_W-1);
  assign cap      = !fsync && tick && owned;

  always_comb begin
    if (mode[2]) begin
      owned     = slot[1:0] == mode[1:0];
      local_idx = slot[HW_W-1:2];
      top_slot  = HW_W'(4*BASE_SLOTS-1);
    end else if (mode[1]) begin
      owned     = slot[0] == mode[0];
      local_idx = slot[LOC_W:1];
      top_slot  = HW_W'(2*BASE_SLOTS-1);
    end else begin
      owned     = 1'b1;
      local_idx = slot[LOC_W-1:0];
      top_slot  = HW_W'(BASE_SLOTS-1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fsync) begin
      phase  <= 1'b0;
      bitcnt <= '0;
      slot   <= '0;
    end else begin
      phase <= dbl_clk ? !phase : 1'b0;
      if (tick) begin
        bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
        if (last_bit) slot <= (slot >= top_slot) ? '0 : slot + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_slot  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cap) begin
        rx_sh <= {rx_sh[BYTE_W-2:0], sdin};
        if (last_bit) begin
          rx_valid <= 1'b1;
          rx_byte  <= {rx_sh[BYTE_W-2:0], sdin};
          rx_slot  <= local_idx;
        end
      end
    end
  end

  assign sdout    = owned & tx_data[BIT_W'(BYTE_W-1) - bitcnt];
  assign sdout_oe = owned && out_en && !out_hiz;
  assign cur_slot = local_idx;

  a_r9_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> !sdout_oe);

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (slot == '0 && bitcnt == '0 && !phase && !rx_valid));

  a_r5_hold_first_half: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_clk && !phase && !fsync) |=> ($stable(bitcnt) && !rx_valid));

  a_r2_wrap_64: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b01 && !fsync && tick && last_bit
     && slot == HW_W'(2*BASE_SLOTS-1)) |=> slot == '0);

  a_r3_wrap_128: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2] && !fsync && tick && last_bit
     && slot == HW_W'(4*BASE_SLOTS-1)) |=> slot == '0);
endmodule

// File: tb/tb_tdm_slot_port.sv
module tb_tdm_slot_port;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0;
  logic [2:0] rate_sel = 3'b000;
  logic fixed_rate = 1'b0, dbl_clk = 1'b0, out_hiz = 1'b0, out_en = 1'b1, sdin = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sdout, sdout_oe, rx_valid;
  logic [4:0] cur_slot, rx_slot;
  logic [7:0] rx_byte;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tdm_slot_port dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rate_sel(rate_sel),
    .fixed_rate(fixed_rate), .dbl_clk(dbl_clk), .out_hiz(out_hiz),
    .out_en(out_en), .sdin(sdin), .tx_data(tx_data), .sdout(sdout),
    .sdout_oe(sdout_oe), .cur_slot(cur_slot), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_slot(rx_slot));

  // {fixed, dbl, hiz, en, rate[2:0]}
  localparam logic [6:0] CFGS [8] = '{
    7'b0_0_0_1_000, 7'b0_0_0_1_010, 7'b0_1_0_1_011, 7'b0_0_0_1_100,
    7'b0_1_0_1_111, 7'b0_0_1_1_110, 7'b1_0_0_1_101, 7'b0_1_0_0_000};

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] txpat(int l);  return 8'(l * 29 + 8'h5A); endfunction
  function automatic logic [7:0] rxpat(int s);  return 8'(s * 37 + 5);     endfunction

  task automatic run_frame(logic [6:0] cfg, int max_iter);
    logic [2:0] eff;
    int nsl, nph, iter;
    bit prev_cap;
    int prev_slot, prev_local;
    string mtag;
    eff = cfg[6] ? 3'b000 : cfg[2:0];
    nsl = eff[2] ? 128 : (eff[1] ? 64 : 32);
    nph = cfg[5] ? 2 : 1;
    mtag = cfg[6] ? "R4" : (eff[2] ? "R3" : (eff[1] ? "R2" : "R1"));
    @(negedge clk);
    fixed_rate = cfg[6]; dbl_clk = cfg[5]; out_hiz = cfg[4];
    out_en = cfg[3]; rate_sel = cfg[2:0]; fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    #2 chk("R6 no capture on sync edge", int'(rx_valid), 0);
    prev_cap = 1'b0; prev_slot = 0; prev_local = 0; iter = 0;
    for (int s = 0; s < nsl; s++) begin
      for (int b = 0; b < 8; b++) begin
        for (int p = 0; p < nph; p++) begin
          bit own;
          int loc;
          if (iter >= max_iter) return;
          iter++;
          own = eff[2] ? (s % 4 == int'(eff[1:0])) : (eff[1] ? (s % 2 == int'(eff[0])) : 1'b1);
          loc = eff[2] ? s / 4 : (eff[1] ? s / 2 : s);
          sdin = rxpat(s)[7-b];
          tx_data = txpat(loc);
          #2;
          chk(cfg[5] ? "R5 strobe timing" : "R8 strobe timing", int'(rx_valid), int'(prev_cap));
          if (prev_cap) begin
            chk("R8 rx_byte", int'(rx_byte), int'(rxpat(prev_slot)));
            chk("R8 rx_slot", int'(rx_slot), prev_local);
          end
          chk(mtag, int'(cur_slot), loc);
          chk("R9 sdout_oe", int'(sdout_oe), int'(own && cfg[3] && !cfg[4]));
          if (own) chk("R7 sdout", int'(sdout), int'(txpat(loc)[7-b]));
          prev_cap = own && (p == nph - 1) && (b == 7);
          prev_slot = s; prev_local = loc;
          @(negedge clk);
        end
      end
    end
    #2 chk("R8 last strobe", int'(rx_valid), int'(prev_cap));
    if (prev_cap) chk("R8 last byte", int'(rx_byte), int'(rxpat(prev_slot)));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R10 rx_valid in reset", int'(rx_valid), 0);
    chk("R10 slot in reset", int'(cur_slot), 0);
    chk("R10 bit 0 in reset", int'(sdout), int'(tx_data[7]));
    @(negedge clk); rst_n = 1'b1;
    foreach (CFGS[i]) run_frame(CFGS[i], 1 << 30);
    // mid-frame resync: partial frames, then a full one
    run_frame(7'b0_0_0_1_000, 13);
    run_frame(7'b0_1_0_1_100, 29);
    run_frame(7'b0_0_0_1_011, 1 << 30);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule